// File: doc/BRIEF.md
# Banked Register Mode Switcher

This block keeps the per-mode copies of the registers that a small 32-bit processor swaps when its operating mode changes. There are six banks. Each bank holds a stack pointer, a link register and a saved status word. There is also a pair of five-register sets for general registers 8 to 12. One set is the ordinary copy and the other is private to the fast-interrupt mode. The core presents its current mode, the requested mode and its live register values together with a one-cycle request. The block stores the live values into the bank of the mode being left and returns the values the core must load for the mode being entered. It then signals completion.

User and system modes share a single bank. Supervisor, abort, undefined, interrupt and fast-interrupt modes each have a bank of their own. Only a transition into or out of the fast-interrupt mode exchanges registers 8 to 12. Every other transition hands the live values of those registers straight back. A request that carries a mode code outside the known set raises an error pulse and changes nothing.

Top module: `bank_switch`

## Requirements
- R1: After reset, `done` and `mode_err` are 0, every output register value is 0, and every bank and both five-register sets hold 0.
- R2: A request whose two mode codes are both legal produces `done` high for exactly the one cycle after the request cycle. The outputs are valid in that cycle.
- R3: Mode codes are USR=0x10, FIQ=0x11, IRQ=0x12, SVC=0x13, ABT=0x17, UND=0x1B and SYS=0x1F. USR and SYS share one bank, and each of the other five modes has its own bank, for six banks in total.
- R4: If the requested mode equals the current mode, no bank or set is written. `sp_out`, `lr_out`, `psr_out` and `hi_out` equal the live inputs of the request cycle.
- R5: On a change between modes with different banks, the live stack pointer, link register and status are written into the old mode's bank. The outputs carry the values the new mode's bank held before that write.
- R6: On a change between USR and SYS, the shared bank receives the live values, and the outputs equal those same live values.
- R7: On entering FIQ from any other mode, live registers 8 to 12 are stored into the ordinary set, and `hi_out` carries the fast-interrupt set.
- R8: On leaving FIQ for any other mode, live registers 8 to 12 are stored into the fast-interrupt set, and `hi_out` carries the ordinary set.
- R9: On any change that neither enters nor leaves FIQ, `hi_out` equals the live `live_hi_in` of the request cycle.
- R10: A request with an illegal current or requested code pulses `mode_err` for one cycle, gives no `done`, leaves all outputs unchanged, and writes no bank or set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Mode-change request, one cycle per request |
| cur_mode | input | 5 | Mode code the core is leaving |
| new_mode | input | 5 | Mode code the core is entering |
| live_sp_in | input | 32 | Live stack pointer |
| live_lr_in | input | 32 | Live link register |
| live_psr_in | input | 32 | Live saved status word |
| live_hi_in | input | 160 | Live registers 8 to 12, register 8 in bits 31:0 |
| done | output | 1 | Switch completed, one-cycle pulse |
| mode_err | output | 1 | Illegal mode code seen, one-cycle pulse |
| sp_out | output | 32 | Stack pointer for the new mode |
| lr_out | output | 32 | Link register for the new mode |
| psr_out | output | 32 | Saved status word for the new mode |
| hi_out | output | 160 | Registers 8 to 12 for the new mode |

## Verification
The bench targets a USR-to-SYS change. A design that reads the shared bank before writing it would return stale values instead of the live ones. The bench also makes a same-mode request while in FIQ, then leaves FIQ. A design that treated the same-mode request as an entry would overwrite the ordinary set, and a later exit would return the wrong registers 8 to 12. Illegal codes on either mode input are followed by a legal switch, which exposes any bank or set that the rejected request wrongly wrote. A reset in mid-run, followed by a switch into a bank filled earlier, shows whether reset truly clears the storage.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int MODE_W = 5;
  localparam int NUM_BANKS = 6;
  localparam int IDX_W = $clog2(NUM_BANKS);

  localparam logic [MODE_W-1:0] M_USR = 5'h10;
  localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] M_SVC = 5'h13;
  localparam logic [MODE_W-1:0] M_ABT = 5'h17;
  localparam logic [MODE_W-1:0] M_UND = 5'h1B;
  localparam logic [MODE_W-1:0] M_SYS = 5'h1F;

  typedef struct packed {
    logic             ok;
    logic [IDX_W-1:0] idx;
  } bank_sel_t;

  // Mode code to bank slot; user and system fold onto slot 0.
  function automatic bank_sel_t map_bank(input logic [MODE_W-1:0] m);
    bank_sel_t s;
    s.ok  = 1'b1;
    s.idx = '0;
    case (m)
      M_USR, M_SYS: s.idx = IDX_W'(0);
      M_SVC:        s.idx = IDX_W'(1);
      M_ABT:        s.idx = IDX_W'(2);
      M_UND:        s.idx = IDX_W'(3);
      M_IRQ:        s.idx = IDX_W'(4);
      M_FIQ:        s.idx = IDX_W'(5);
      default:      s.ok  = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/bank_store.sv
module bank_store #(
  parameter int W = 32,
  parameter int NB = 6,
  parameter int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_sp,
  input  logic [W-1:0]  wr_lr,
  input  logic [W-1:0]  wr_psr,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_sp,
  output logic [W-1:0]  rd_lr,
  output logic [W-1:0]  rd_psr
);
  logic [W-1:0] sp_q  [NB];
  logic [W-1:0] lr_q  [NB];
  logic [W-1:0] psr_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sp_q[g]  <= '0;
        lr_q[g]  <= '0;
        psr_q[g] <= '0;
      end else if (we && wr_idx == IW'(g)) begin
        sp_q[g]  <= wr_sp;
        lr_q[g]  <= wr_lr;
        psr_q[g] <= wr_psr;
      end
    end
  end

  always_comb begin
    rd_sp  = '0;
    rd_lr  = '0;
    rd_psr = '0;
    for (int i = 0; i < NB; i++) begin
      if (rd_idx == IW'(i)) begin
        rd_sp  = sp_q[i];
        rd_lr  = lr_q[i];
        rd_psr = psr_q[i];
      end
    end
  end
endmodule

// File: rtl/fiq_shadow.sv
module fiq_shadow #(
  parameter int W = 32,
  parameter int N = 5,
  parameter int HW = W * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_usr,
  input  logic          save_fiq,
  input  logic [HW-1:0] live_hi,
  output logic [HW-1:0] usr_hi,
  output logic [HW-1:0] fiq_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      usr_hi <= '0;
      fiq_hi <= '0;
    end else begin
      if (save_usr) usr_hi <= live_hi;
      if (save_fiq) fiq_hi <= live_hi;
    end
  end
endmodule

// File: rtl/bank_switch.sv
module bank_switch #(
  parameter int W = 32,
  parameter int NHI = 5,
  parameter int HW = W * NHI
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [bank_pkg::MODE_W-1:0] cur_mode,
  input  logic [bank_pkg::MODE_W-1:0] new_mode,
  input  logic [W-1:0]               live_sp_in,
  input  logic [W-1:0]               live_lr_in,
  input  logic [W-1:0]               live_psr_in,
  input  logic [HW-1:0]              live_hi_in,
  output logic                       done,
  output logic                       mode_err,
  output logic [W-1:0]               sp_out,
  output logic [W-1:0]               lr_out,
  output logic [W-1:0]               psr_out,
  output logic [HW-1:0]              hi_out
);
  import bank_pkg::*;

  bank_sel_t cur_sel, new_sel;
  logic legal_req, bad_req, same_mode, do_switch;
  logic enter_fiq, leave_fiq, shared_bank;
  logic [W-1:0]  rd_sp, rd_lr, rd_psr;
  logic [W-1:0]  nx_sp, nx_lr, nx_psr;
  logic [HW-1:0] usr_hi, fiq_hi, nx_hi;

  assign cur_sel     = map_bank(cur_mode);
  assign new_sel     = map_bank(new_mode);
  assign legal_req   = req_valid && cur_sel.ok && new_sel.ok;
  assign bad_req     = req_valid && !(cur_sel.ok && new_sel.ok);
  assign same_mode   = (cur_mode == new_mode);
  assign do_switch   = legal_req && !same_mode;
  assign enter_fiq   = do_switch && (new_mode == M_FIQ);
  assign leave_fiq   = do_switch && (cur_mode == M_FIQ);
  assign shared_bank = (cur_sel.idx == new_sel.idx);

  bank_store #(.W(W), .NB(NUM_BANKS), .IW(IDX_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (do_switch),
    .wr_idx (cur_sel.idx),
    .wr_sp  (live_sp_in),
    .wr_lr  (live_lr_in),
    .wr_psr (live_psr_in),
    .rd_idx (new_sel.idx),
    .rd_sp  (rd_sp),
    .rd_lr  (rd_lr),
    .rd_psr (rd_psr)
  );

  fiq_shadow #(.W(W), .N(NHI), .HW(HW)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .save_usr (enter_fiq),
    .save_fiq (leave_fiq),
    .live_hi  (live_hi_in),
    .usr_hi   (usr_hi),
    .fiq_hi   (fiq_hi)
  );

  // Same mode or same bank: the freshly saved live values are the answer.
  always_comb begin
    if (same_mode || shared_bank) begin
      nx_sp  = live_sp_in;
      nx_lr  = live_lr_in;
      nx_psr = live_psr_in;
    end else begin
      nx_sp  = rd_sp;
      nx_lr  = rd_lr;
      nx_psr = rd_psr;
    end
    if (enter_fiq)      nx_hi = fiq_hi;
    else if (leave_fiq) nx_hi = usr_hi;
    else                nx_hi = live_hi_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      mode_err <= 1'b0;
      sp_out   <= '0;
      lr_out   <= '0;
      psr_out  <= '0;
      hi_out   <= '0;
    end else begin
      done     <= legal_req;
      mode_err <= bad_req;
      if (legal_req) begin
        sp_out  <= nx_sp;
        lr_out  <= nx_lr;
        psr_out <= nx_psr;
        hi_out  <= nx_hi;
      end
    end
  end
endmodule

// File: rtl/bank_switch_chk.sv
module bank_switch_chk #(
  parameter int W = 32,
  parameter int HW = 160
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          done,
  input logic          mode_err,
  input logic [W-1:0]  sp_out,
  input logic [HW-1:0] hi_out,
  input logic [W-1:0]  live_sp_in,
  input logic [HW-1:0] live_hi_in,
  input logic          legal_req,
  input logic          same_mode,
  input logic          enter_fiq,
  input logic          leave_fiq
);
  // R2
  legal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legal_req |=> done);
  // R2
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid));
  // R10
  err_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !done);
  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> ($stable(sp_out) && $stable(hi_out)));
  // R4
  same_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_req && same_mode) |=> (sp_out == $past(live_sp_in)));
  // R9
  hi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_req && !enter_fiq && !leave_fiq) |=> (hi_out == $past(live_hi_in)));
endmodule

bind bank_switch bank_switch_chk #(.W(W), .HW(HW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .done       (done),
  .mode_err   (mode_err),
  .sp_out     (sp_out),
  .hi_out     (hi_out),
  .live_sp_in (live_sp_in),
  .live_hi_in (live_hi_in),
  .legal_req  (legal_req),
  .same_mode  (same_mode),
  .enter_fiq  (enter_fiq),
  .leave_fiq  (leave_fiq)
);

// File: tb/bank_switch_bench.sv
`timescale 1ns/1ps
module bank_switch_bench;
  localparam int W = 32;
  localparam int NHI = 5;
  localparam int HW = W * NHI;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [4:0] cur_mode = 5'h10, new_mode = 5'h10;
  logic [W-1:0] live_sp_in = '0, live_lr_in = '0, live_psr_in = '0;
  logic [HW-1:0] live_hi_in = '0;
  logic done, mode_err;
  logic [W-1:0] sp_out, lr_out, psr_out;
  logic [HW-1:0] hi_out;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bank_switch u_bank_switch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .cur_mode(cur_mode), .new_mode(new_mode),
    .live_sp_in(live_sp_in), .live_lr_in(live_lr_in),
    .live_psr_in(live_psr_in), .live_hi_in(live_hi_in),
    .done(done), .mode_err(mode_err),
    .sp_out(sp_out), .lr_out(lr_out), .psr_out(psr_out), .hi_out(hi_out)
  );

  typedef struct packed {
    logic [4:0]  cm;
    logic [4:0]  nm;
    logic [31:0] live;
    logic [31:0] lseed;
    logic [31:0] esp;
    logic [31:0] eseed;
  } vec_t;

  // live sp/lr/psr = live, live+1, live+2; expected likewise from esp (0 = all zero).
  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{5'h10, 5'h13, 32'h100, 32'h500,  32'h0,   32'h500},  // R3 R5 R9
    '{5'h13, 5'h12, 32'h200, 32'h600,  32'h0,   32'h600},  // R5 R9
    '{5'h12, 5'h13, 32'h300, 32'h700,  32'h200, 32'h700},  // R5 saved SVC returns
    '{5'h13, 5'h11, 32'h400, 32'h800,  32'h0,   32'h0},    // R7 enter FIQ
    '{5'h11, 5'h10, 32'h500, 32'h900,  32'h100, 32'h800},  // R8 leave FIQ
    '{5'h10, 5'h1F, 32'h600, 32'hA00,  32'h600, 32'hA00},  // R6 shared bank
    '{5'h1F, 5'h1F, 32'h700, 32'hB00,  32'h700, 32'hB00},  // R4 same mode
    '{5'h1F, 5'h11, 32'h800, 32'hC00,  32'h500, 32'h900},  // R7
    '{5'h11, 5'h11, 32'h850, 32'hC80,  32'h850, 32'hC80},  // R4 in FIQ
    '{5'h11, 5'h17, 32'h900, 32'hD00,  32'h0,   32'hC00},  // R8 R4 set kept
    '{5'h17, 5'h1B, 32'hA00, 32'hE00,  32'h0,   32'hE00},  // R3 R9
    '{5'h1B, 5'h17, 32'hB00, 32'hF00,  32'hA00, 32'hF00},  // R5
    '{5'h17, 5'h10, 32'hC00, 32'h1000, 32'h800, 32'h1000}, // R3 R6 written from SYS
    '{5'h10, 5'h11, 32'hD00, 32'h1100, 32'h900, 32'hD00}   // R7
  };

  function automatic logic [HW-1:0] hi_of(input logic [31:0] seed);
    logic [HW-1:0] v = '0;
    if (seed != 0)
      for (int i = 0; i < NHI; i++) v[i*W +: W] = seed + 32'(i);
    return v;
  endfunction

  task automatic check(input string tag, input logic [HW-1:0] act, input logic [HW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag, input logic [31:0] esp, input logic [31:0] eseed);
    logic [31:0] e1 = (esp == 0) ? 32'h0 : esp + 1;
    logic [31:0] e2 = (esp == 0) ? 32'h0 : esp + 2;
    check({tag, " sp R5"}, HW'(sp_out), HW'(esp));
    check({tag, " lr R5"}, HW'(lr_out), HW'(e1));
    check({tag, " psr R5"}, HW'(psr_out), HW'(e2));
    check({tag, " hi R7/R8/R9"}, hi_out, hi_of(eseed));
  endtask

  // Drive at negedge, result visible one edge later, then confirm the pulse ends.
  task automatic issue(input logic [4:0] cm, input logic [4:0] nm,
                       input logic [31:0] live, input logic [31:0] seed,
                       input logic exp_done, input logic exp_err);
    @(negedge clk);
    req_valid   = 1'b1;
    cur_mode    = cm;
    new_mode    = nm;
    live_sp_in  = live;
    live_lr_in  = live + 1;
    live_psr_in = live + 2;
    live_hi_in  = hi_of(seed);
    @(negedge clk);
    req_valid = 1'b0;
    check("done R2", HW'(done), HW'(exp_done));
    check("mode_err R10", HW'(mode_err), HW'(exp_err));
  endtask

  task automatic pulse_end(input string tag);
    @(negedge clk);
    check({tag, " done single R2"}, HW'(done), HW'(0));
    check({tag, " err single R10"}, HW'(mode_err), HW'(0));
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("reset done R1", HW'(done), HW'(0));
    check("reset err R1", HW'(mode_err), HW'(0));
    check_regs("reset R1", 32'h0, 32'h0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      issue(TBL[k].cm, TBL[k].nm, TBL[k].live, TBL[k].lseed, 1'b1, 1'b0);
      check_regs($sformatf("vec%0d", k), TBL[k].esp, TBL[k].eseed);
      pulse_end($sformatf("vec%0d", k));
    end

    // R10 illegal requested code while in FIQ: outputs hold
    issue(5'h11, 5'h14, 32'hEE0, 32'hEE00, 1'b0, 1'b1);
    check_regs("bad new R10", 32'h900, 32'hD00);
    pulse_end("bad new");
    // R10 illegal current code
    issue(5'h00, 5'h10, 32'hEF0, 32'hEF00, 1'b0, 1'b1);
    check_regs("bad cur R10", 32'h900, 32'hD00);
    pulse_end("bad cur");
    // R10 nothing was stored: leave FIQ, bank 0 and ordinary set intact
    issue(5'h11, 5'h10, 32'hE00, 32'h1200, 1'b1, 1'b0);
    check_regs("after bad R10 R8", 32'hD00, 32'h1100);
    pulse_end("after bad");

    // R1 mid-run reset clears the banks
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_regs("rerst R1", 32'h0, 32'h0);
    rst_n = 1'b1;
    issue(5'h10, 5'h12, 32'hF00, 32'h1300, 1'b1, 1'b0);
    check_regs("post rst bank R1", 32'h0, 32'h1300);
    pulse_end("post rst");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule